// File: doc/BRIEF.md
# Cycle-State Indexed Control Register Bank

This block holds the control settings for a beam-processing datapath. Most settings are indexed: each one keeps a separate value for every phase of the accelerator's repeating machine cycle. The datapath sees one live value per indexed setting, which is the copy belonging to the active phase. A small set of global settings has one value each and is not indexed. A host can write or read any stored copy at any time through a simple write port and a pipelined read port.

An external phase input reports each new machine phase with a strobe. The block does not apply a new phase straight away. It records the phase and waits for the next start-of-turn marker. At that marker, the active phase index and every live indexed value change together, so the datapath never sees settings from two phases within one turn.

At every marker the live values are also reloaded from storage. As a result, a host edit to the active phase's copy reaches the datapath at the next turn boundary. A two-state sequencer controls the switching:
- SEQ_IDLE means no phase change is waiting.
- SEQ_ARMED means a strobed phase is waiting for a marker.
- Transitions:
  - SEQ_IDLE goes to SEQ_ARMED on a phase strobe.
  - SEQ_ARMED stays in SEQ_ARMED on a further strobe, which replaces the waiting phase.
  - SEQ_ARMED returns to SEQ_IDLE on a marker that comes without a strobe in the same cycle.
  - Any other case holds the current state.

Top module: `cyc_ctl_bank`

## Requirements
- R1: After reset, these are all zero: every stored indexed copy, every global setting, every live value and the active phase index.
- R2: A host write with `wr_master`=0 stores `wr_data` into the copy addressed by (`wr_reg`, `wr_state`). A later read of that address returns it.
- R3: A read request is served in exactly 2 cycles. `rd_valid` is high on the second clock edge after the edge that samples `rd_en`, and `rd_data` is valid at the same time. `rd_master`=1 selects the global settings, and a global index of `NUM_MASTER` or above reads as 0.
- R4: While `turn_start` is low, no live value and no bit of `cur_state` changes, whatever phase strobes or host writes occur.
- R5: At a marker after a phase strobe, `cur_state` becomes the strobed phase on that clock edge. On the same edge, every live value becomes that phase's stored copy.
- R6: If several strobes arrive before a marker, the last one wins. A strobe in the same cycle as a marker is not applied by that marker; it is applied at the following marker.
- R7: A host write to a copy of the active phase leaves the live value alone until the next marker, and that marker makes it live.
- R8: A host write to a copy of a phase that is not active does not change any live value at a marker that keeps the active phase.
- R9: A global setting takes its written value on the clock edge that samples the write. Phase strobes and markers do not change global settings. A global write to index `NUM_MASTER` or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write request |
| wr_master | input | 1 | 1 selects the global settings, 0 selects the indexed copies |
| wr_reg | input | REG_W | Setting index |
| wr_state | input | STATE_W | Phase index of the copy (indexed writes only) |
| wr_data | input | DATA_W | Write value |
| rd_en | input | 1 | Host read request |
| rd_master | input | 1 | 1 reads a global setting, 0 reads an indexed copy |
| rd_reg | input | REG_W | Setting index to read |
| rd_state | input | STATE_W | Phase index to read |
| rd_valid | output | 1 | Read data valid, 2 cycles after the request |
| rd_data | output | DATA_W | Read value |
| state_valid | input | 1 | Strobe marking a new machine phase on `state_in` |
| state_in | input | STATE_W | Reported machine phase |
| turn_start | input | 1 | Start-of-turn marker |
| cur_state | output | STATE_W | Active phase index |
| live_data | output | NUM_REGS*DATA_W | Live indexed values, setting r at bits [r*DATA_W +: DATA_W] |
| master_data | output | NUM_MASTER*DATA_W | Global settings, index m at bits [m*DATA_W +: DATA_W] |

## Verification
A corrupted stored copy stays hidden until a marker selects its phase. The bench therefore writes a distinct value into every (setting, phase) pair and reads each pair back. It then moves the active phase through all sixteen indices, so each copy reaches `live_data` at least once. A sequencer stuck in SEQ_IDLE or SEQ_ARMED, or a captured phase that was dropped, shows on `cur_state` and on every live lane on the very edge of the marker that should have switched them. Markers are kept a few cycles after each strobe so that an early switch is also caught within those cycles.

// File: rtl/cyc_ctl_pkg.sv
package cyc_ctl_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

endpackage

// File: rtl/cyc_ctl_store.sv
module cyc_ctl_store #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int STATE_W  = 4,
    parameter int REG_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [REG_W-1:0]           wr_reg,
    input  logic [STATE_W-1:0]         wr_state,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [REG_W-1:0]           rd_reg,
    input  logic [STATE_W-1:0]         rd_state,
    output logic [DATA_W-1:0]          rd_data,
    input  logic [STATE_W-1:0]         row_state,
    output logic [NUM_REGS*DATA_W-1:0] row_data
);
    localparam int NUM_STATES = 1 << STATE_W;

    logic [DATA_W-1:0] mem [NUM_REGS][NUM_STATES];

    // one bank of per-phase copies for each indexed setting
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NUM_STATES; s++) begin
                    mem[r][s] <= '0;
                end
            end else if (wr_en && (wr_reg == REG_W'(r))) begin
                mem[r][wr_state] <= wr_data;
            end
        end

        assign row_data[r*DATA_W +: DATA_W] = mem[r][row_state];
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (rd_reg == REG_W'(r)) begin
                rd_data = mem[r][rd_state];
            end
        end
    end

endmodule

// File: rtl/cyc_ctl_master.sv
module cyc_ctl_master #(
    parameter int NUM_MASTER = 2,
    parameter int DATA_W     = 16,
    parameter int REG_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [REG_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [REG_W-1:0]             rd_idx,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_MASTER*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] regs [NUM_MASTER];

    for (genvar m = 0; m < NUM_MASTER; m++) begin : g_mst
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[m] <= '0;
            end else if (wr_en && (wr_idx == REG_W'(m))) begin
                regs[m] <= wr_data;
            end
        end

        assign flat[m*DATA_W +: DATA_W] = regs[m];
    end

    // indices with no matching setting read as zero
    always_comb begin
        rd_data = '0;
        for (int m = 0; m < NUM_MASTER; m++) begin
            if (rd_idx == REG_W'(m)) begin
                rd_data = regs[m];
            end
        end
    end

endmodule

// File: rtl/cyc_ctl_seq.sv
module cyc_ctl_seq
    import cyc_ctl_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               state_valid,
    input  logic [STATE_W-1:0] state_in,
    input  logic               turn_start,
    output logic               load,
    output logic [STATE_W-1:0] load_state,
    output logic [STATE_W-1:0] active_state
);
    seq_state_t         seq_q, seq_d;
    logic [STATE_W-1:0] pend_q, pend_d;
    logic [STATE_W-1:0] act_q, act_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q  <= SEQ_IDLE;
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            seq_q  <= seq_d;
            pend_q <= pend_d;
            act_q  <= act_d;
        end
    end

    // next state
    always_comb begin
        seq_d  = seq_q;
        pend_d = state_valid ? state_in : pend_q;
        unique case (seq_q)
            SEQ_IDLE:  if (state_valid) seq_d = SEQ_ARMED;
            SEQ_ARMED: if (turn_start && !state_valid) seq_d = SEQ_IDLE;
        endcase
    end

    // outputs: phase to load at this marker, and the active phase
    always_comb begin
        load       = turn_start;
        load_state = (seq_q == SEQ_ARMED) ? pend_q : act_q;
        act_d      = turn_start ? load_state : act_q;
    end

    assign active_state = act_q;

endmodule

// File: rtl/cyc_ctl_bank.sv
module cyc_ctl_bank #(
    parameter int NUM_REGS   = 4,
    parameter int NUM_MASTER = 2,
    parameter int DATA_W     = 16,
    parameter int STATE_W    = 4,
    parameter int REG_MAX    = (NUM_REGS > NUM_MASTER) ? NUM_REGS : NUM_MASTER,
    parameter int REG_W      = (REG_MAX > 1) ? $clog2(REG_MAX) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_master,
    input  logic [REG_W-1:0]             wr_reg,
    input  logic [STATE_W-1:0]           wr_state,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    input  logic                         rd_master,
    input  logic [REG_W-1:0]             rd_reg,
    input  logic [STATE_W-1:0]           rd_state,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         state_valid,
    input  logic [STATE_W-1:0]           state_in,
    input  logic                         turn_start,
    output logic [STATE_W-1:0]           cur_state,
    output logic [NUM_REGS*DATA_W-1:0]   live_data,
    output logic [NUM_MASTER*DATA_W-1:0] master_data
);
    logic                       load;
    logic [STATE_W-1:0]         load_state;
    logic [NUM_REGS*DATA_W-1:0] row_data;
    logic [NUM_REGS*DATA_W-1:0] live_q;
    logic [DATA_W-1:0]          idx_rd, mst_rd;

    logic                       s1_v, s1_m, s2_v;
    logic [REG_W-1:0]           s1_reg;
    logic [STATE_W-1:0]         s1_st;
    logic [DATA_W-1:0]          s2_data;

    cyc_ctl_seq #(.STATE_W(STATE_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .state_valid(state_valid), .state_in(state_in),
        .turn_start(turn_start),
        .load(load), .load_state(load_state), .active_state(cur_state)
    );

    cyc_ctl_store #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .STATE_W(STATE_W), .REG_W(REG_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && !wr_master), .wr_reg(wr_reg),
        .wr_state(wr_state), .wr_data(wr_data),
        .rd_reg(s1_reg), .rd_state(s1_st), .rd_data(idx_rd),
        .row_state(load_state), .row_data(row_data)
    );

    cyc_ctl_master #(
        .NUM_MASTER(NUM_MASTER), .DATA_W(DATA_W), .REG_W(REG_W)
    ) mst_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_master), .wr_idx(wr_reg), .wr_data(wr_data),
        .rd_idx(s1_reg), .rd_data(mst_rd), .flat(master_data)
    );

    // live copies switch only at a turn marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (load) begin
            live_q <= row_data;
        end
    end

    // two-stage host read: address capture, then data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_m    <= 1'b0;
            s1_reg  <= '0;
            s1_st   <= '0;
            s2_v    <= 1'b0;
            s2_data <= '0;
        end else begin
            s1_v   <= rd_en;
            s1_m   <= rd_master;
            s1_reg <= rd_reg;
            s1_st  <= rd_state;
            s2_v   <= s1_v;
            if (s1_v) begin
                s2_data <= s1_m ? mst_rd : idx_rd;
            end
        end
    end

    assign live_data = live_q;
    assign rd_valid  = s2_v;
    assign rd_data   = s2_data;

endmodule

// File: rtl/cyc_ctl_bank_chk.sv
module cyc_ctl_bank_chk #(
    parameter int NUM_REGS   = 4,
    parameter int NUM_MASTER = 2,
    parameter int DATA_W     = 16,
    parameter int STATE_W    = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic                         wr_master,
    input logic                         rd_en,
    input logic                         rd_valid,
    input logic                         state_valid,
    input logic [STATE_W-1:0]           state_in,
    input logic                         turn_start,
    input logic [STATE_W-1:0]           cur_state,
    input logic [NUM_REGS*DATA_W-1:0]   live_data,
    input logic [NUM_MASTER*DATA_W-1:0] master_data
);
    // R4: nothing live moves between markers
    a_r4_hold_mid_turn: assert property (@(posedge clk) disable iff (!rst_n)
        !turn_start |=> ($stable(live_data) && $stable(cur_state)));

    // R3: a request yields valid data two edges later
    a_r3_rd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ##1 rd_valid);

    // R3: no valid without a request two edges earlier
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en, 2));

    // R9: global settings change only through a global write
    a_r9_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_master) |=> $stable(master_data));

    // R5: strobe then a clean marker selects the strobed phase
    a_r5_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_valid ##1 (turn_start && !state_valid)) |=>
            (cur_state == $past(state_in, 2)));

endmodule

bind cyc_ctl_bank cyc_ctl_bank_chk #(
    .NUM_REGS(NUM_REGS), .NUM_MASTER(NUM_MASTER),
    .DATA_W(DATA_W), .STATE_W(STATE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_master(wr_master),
    .rd_en(rd_en), .rd_valid(rd_valid),
    .state_valid(state_valid), .state_in(state_in), .turn_start(turn_start),
    .cur_state(cur_state), .live_data(live_data), .master_data(master_data)
);

// File: tb/cyc_ctl_bank_tb_top.sv
module cyc_ctl_bank_tb_top;
    localparam int NR = 4;
    localparam int NM = 2;
    localparam int DW = 16;
    localparam int SW = 4;
    localparam int NS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_master = 0, rd_en = 0, rd_master = 0;
    logic [1:0] wr_reg = '0, rd_reg = '0;
    logic [SW-1:0] wr_state = '0, rd_state = '0, state_in = '0;
    logic [DW-1:0] wr_data = '0;
    logic state_valid = 0, turn_start = 0;
    logic rd_valid;
    logic [DW-1:0] rd_data;
    logic [SW-1:0] cur_state;
    logic [NR*DW-1:0] live_data;
    logic [NM*DW-1:0] master_data;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] exp_mem [NR][NS];
    logic [DW-1:0] exp_live [NR];
    logic [SW-1:0] exp_act = '0, exp_pend = '0;
    logic          exp_armed = 1'b0;

    always #2.5 clk = ~clk;

    cyc_ctl_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_master(wr_master), .wr_reg(wr_reg),
        .wr_state(wr_state), .wr_data(wr_data),
        .rd_en(rd_en), .rd_master(rd_master), .rd_reg(rd_reg),
        .rd_state(rd_state), .rd_valid(rd_valid), .rd_data(rd_data),
        .state_valid(state_valid), .state_in(state_in), .turn_start(turn_start),
        .cur_state(cur_state), .live_data(live_data), .master_data(master_data)
    );

    function automatic logic [DW-1:0] pat(int r, int s);
        return {4'(r + 1), 4'(s), 8'(r * 16 + s + 1)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic chk_live(string req);
        for (int r = 0; r < NR; r++) begin
            chk(req, 32'(live_data[r*DW +: DW]), 32'(exp_live[r]));
        end
        chk(req, 32'(cur_state), 32'(exp_act));
    endtask

    task automatic wr(logic m, int idx, int st, logic [DW-1:0] d);
        wr_en = 1; wr_master = m; wr_reg = 2'(idx); wr_state = SW'(st); wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_master = 0;
        if (!m) exp_mem[idx][st] = d;
    endtask

    task automatic rd(string req, logic m, int idx, int st, logic [DW-1:0] expv);
        rd_en = 1; rd_master = m; rd_reg = 2'(idx); rd_state = SW'(st);
        @(negedge clk);
        rd_en = 0; rd_master = 0;
        chk(req, 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk(req, 32'(rd_valid), 32'd1);
        chk(req, 32'(rd_data), 32'(expv));
    endtask

    // model of a marker: pending phase (if any) becomes active, lanes reload
    task automatic model_marker();
        if (exp_armed) exp_act = exp_pend;
        exp_armed = 1'b0;
        for (int r = 0; r < NR; r++) exp_live[r] = exp_mem[r][exp_act];
    endtask

    task automatic strobe(int s);
        state_valid = 1; state_in = SW'(s);
        @(negedge clk);
        state_valid = 0;
        exp_pend = SW'(s); exp_armed = 1'b1;
    endtask

    task automatic marker();
        turn_start = 1;
        @(negedge clk);
        turn_start = 0;
        model_marker();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end (actual=hung expected=done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            exp_live[r] = '0;
            for (int s = 0; s < NS; s++) exp_mem[r][s] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset values
        chk_live("R1 live/state");
        chk("R1 master", 32'(master_data), 32'd0);
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        rd("R1 stored copy", 1'b0, 3, 15, '0);

        // R2: fill every copy, then read each back
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < NS; s++) wr(1'b0, r, s, pat(r, s));
        chk_live("R7 no live change before marker");
        for (int r = 0; r < NR; r++)
            for (int s = 0; s < NS; s++) rd("R2 readback", 1'b0, r, s, pat(r, s));

        // R7: active phase 0 copies go live at the marker
        marker();
        chk_live("R7 active edits live at marker");

        // R4 / R5: sweep all phases
        for (int s = 1; s < NS; s++) begin
            strobe(s);
            repeat (2) @(negedge clk);
            chk_live("R4 held until marker");
            marker();
            chk_live("R5 switch at marker");
        end

        // R7: edit the active copy
        wr(1'b0, 2, 15, 16'hA5A5);
        @(negedge clk);
        chk("R7 not before marker", 32'(live_data[2*DW +: DW]), 32'(pat(2, 15)));
        marker();
        chk("R7 at marker", 32'(live_data[2*DW +: DW]), 32'h0000A5A5);
        chk_live("R7 lanes");

        // R8: edit an inactive copy
        wr(1'b0, 1, 5, 16'h5A5A);
        marker();
        chk("R8 inactive edit", 32'(live_data[1*DW +: DW]), 32'(pat(1, 15)));
        chk_live("R8 lanes");

        // R6: last strobe wins
        strobe(3);
        strobe(7);
        @(negedge clk);
        marker();
        chk("R6 last wins", 32'(cur_state), 32'd7);
        chk_live("R6 lanes");

        // R6: strobe together with a marker waits for the next marker
        state_valid = 1; state_in = 4'd9; turn_start = 1;
        @(negedge clk);
        state_valid = 0; turn_start = 0;
        model_marker();
        exp_pend = 4'd9; exp_armed = 1'b1;
        chk("R6 same-cycle not applied", 32'(cur_state), 32'd7);
        chk_live("R6 same-cycle lanes");
        @(negedge clk);
        marker();
        chk("R6 applied next marker", 32'(cur_state), 32'd9);
        chk_live("R6 next lanes");

        // R9: global settings
        wr(1'b1, 0, 0, 16'hBEEF);
        chk("R9 immediate", 32'(master_data), 32'h0000BEEF);
        strobe(2);
        marker();
        chk("R9 unaffected by marker", 32'(master_data), 32'h0000BEEF);
        wr(1'b1, 3, 0, 16'h1234);
        chk("R9 out-of-range ignored", 32'(master_data), 32'h0000BEEF);
        rd("R3 global read", 1'b1, 0, 0, 16'hBEEF);
        rd("R3 out-of-range global read", 1'b1, 3, 0, 16'h0000);
        rd("R9 index 1 untouched", 1'b1, 1, 0, 16'h0000);
        chk_live("R5 after global traffic");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule